// File: doc/BRIEF.md
# Timer Count-Source and Capture-Edge Clear Front End

This block sits in front of a 16-bit timer and decides when its two counters move. A prescale counter and a timer counter are held here. In clock mode the prescale counter steps on every clock and rolls over into the timer counter once it reaches a programmable match value. In one of the three edge modes, the timer counter instead steps on rising, falling or both edges of one of two asynchronous capture pins. In those modes each counted edge also zeroes the prescale counter.

A separate clear feature can be enabled. When it is, one chosen edge of one chosen capture pin zeroes both counters. The settings live in an 8-bit control byte that is written through a simple write-enable port. Both capture pins are brought into the clock domain by two-flop synchronizers, and edges are then found by comparing each pin with its registered previous value. The block has an asynchronous active-low reset whose release is synchronized inside the block.

Top module: `tcc_timer_front`

## Requirements
- R1: While reset is asserted, both counters read 0. The control byte resets to 0, which selects clock mode with the clear feature off, so the prescale counter steps on each clock once reset is released.
- R2: In clock mode (control bits 1:0 = 0), the prescale counter increments on each clock. A clock on which it equals the match value sets it to 0 and increments the timer counter instead.
- R3: The 16-bit timer counter wraps from 0xFFFF to 0.
- R4: The edge modes are selected by control bits 1:0: 1 counts rising edges of the selected pin, 2 counts falling edges, and 3 counts both. Each counted edge increments the timer counter and sets the prescale counter to 0. Without an edge, neither counter changes.
- R5: Control bits 3:2 choose the counted pin: 0 selects capture pin 0 and 1 selects capture pin 1. Edges on the other pin are not counted. The values 2 and 3 count nothing.
- R6: When control bit 4 is 1, the edge coded in bits 7:5 sets both counters to 0. The codes are 0 for a rise of pin 0, 1 for a fall of pin 0, 2 for a rise of pin 1 and 3 for a fall of pin 1.
- R7: When bit 4 is 0, or bits 7:5 hold 4 to 7, no capture edge clears the counters.
- R8: When a clear and a count occur on the same clock, both counters become 0.
- R9: A pin change that arrives between two clock edges acts on the counters at the third rising clock edge after it. A pin level must be held for at least two clocks to be seen.
- R10: A control write acts from the clock after the edge that stores it. Counting on the storing edge still follows the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin_i | input | 2 | Asynchronous capture pins |
| ctl_we_i | input | 1 | Control byte write enable |
| ctl_wdata_i | input | 8 | Control byte write data |
| pre_match_i | input | 16 | Prescale match value |
| tmr_cnt_o | output | 16 | Timer counter |
| pre_cnt_o | output | 16 | Prescale counter |

## Verification
Assertions in the counter stage check four things on every clock: the prescale step and rollover rule in clock mode, the single step or hold in edge modes, the zeroing of both counters after a clear event, and the priority of a clear over a count. They only see the decoded event lines, so they cannot show that a control encoding maps to the right pin and edge. The bench scenarios cover that mapping, the ignored pin and reserved codes, the three-edge synchronizer latency, the 0xFFFF wrap and the one-clock delay of a control write.

// File: rtl/tcc_pkg.sv
`timescale 1ns/1ps
package tcc_pkg;
  typedef enum logic [1:0] {
    SRC_CLK  = 2'd0,
    SRC_RISE = 2'd1,
    SRC_FALL = 2'd2,
    SRC_BOTH = 2'd3
  } src_mode_e;

  // field order sets bit positions: [7:5] clr_sel, [4] clr_en, [3:2] pin_sel, [1:0] mode
  typedef struct packed {
    logic [2:0] clr_sel;
    logic       clr_en;
    logic [1:0] pin_sel;
    src_mode_e  mode;
  } ctl_t;

  localparam int NUM_CAP = 2;
  localparam int CTL_W   = $bits(ctl_t);
endpackage

// File: rtl/tcc_rst_sync.sv
`timescale 1ns/1ps
module tcc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/tcc_cap_edge.sv
`timescale 1ns/1ps
module tcc_cap_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= pin_i[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end

    assign rise_o[g] =  sync_q & ~prev_q;
    assign fall_o[g] = ~sync_q &  prev_q;
  end
endmodule

// File: rtl/tcc_event_sel.sv
`timescale 1ns/1ps
module tcc_event_sel
  import tcc_pkg::*;
#(
  parameter int N = NUM_CAP
) (
  input  ctl_t         ctl_i,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] fall_i,
  output logic         clk_mode_o,
  output logic         cnt_evt_o,
  output logic         clr_evt_o
);
  logic sel_rise, sel_fall;
  logic clr_rise, clr_fall;

  always_comb begin
    sel_rise = 1'b0;
    sel_fall = 1'b0;
    clr_rise = 1'b0;
    clr_fall = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (int'(ctl_i.pin_sel) == i) begin
        sel_rise = rise_i[i];
        sel_fall = fall_i[i];
      end
      if (int'(ctl_i.clr_sel[2:1]) == i) begin
        clr_rise = rise_i[i];
        clr_fall = fall_i[i];
      end
    end
  end

  always_comb begin
    clk_mode_o = (ctl_i.mode == SRC_CLK);
    unique case (ctl_i.mode)
      SRC_RISE: cnt_evt_o = sel_rise;
      SRC_FALL: cnt_evt_o = sel_fall;
      SRC_BOTH: cnt_evt_o = sel_rise | sel_fall;
      default:  cnt_evt_o = 1'b0;
    endcase
    clr_evt_o = ctl_i.clr_en & (ctl_i.clr_sel[0] ? clr_fall : clr_rise);
  end
endmodule

// File: rtl/tcc_counters.sv
`timescale 1ns/1ps
module tcc_counters #(
  parameter int TC_W = 16,
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_mode_i,
  input  logic            cnt_evt_i,
  input  logic            clr_evt_i,
  input  logic [PC_W-1:0] match_i,
  output logic [TC_W-1:0] tc_o,
  output logic [PC_W-1:0] pc_o
);
  logic [TC_W-1:0] tc_q, tc_d;
  logic [PC_W-1:0] pc_q, pc_d;
  logic            upd_en;

  always_comb begin
    tc_d   = tc_q;
    pc_d   = pc_q;
    upd_en = clr_evt_i | clk_mode_i | cnt_evt_i;
    if (clr_evt_i) begin
      tc_d = '0;
      pc_d = '0;
    end else if (clk_mode_i) begin
      if (pc_q == match_i) begin
        pc_d = '0;
        tc_d = tc_q + 1'b1;
      end else begin
        pc_d = pc_q + 1'b1;
      end
    end else if (cnt_evt_i) begin
      pc_d = '0;
      tc_d = tc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q <= '0;
      pc_q <= '0;
    end else if (upd_en) begin
      tc_q <= tc_d;
      pc_q <= pc_d;
    end
  end

  assign tc_o = tc_q;
  assign pc_o = pc_q;

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt_i |=> (tc_q == '0) && (pc_q == '0));

  a_r4_edge_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_mode_i && cnt_evt_i && !clr_evt_i)
      |=> (tc_q == TC_W'($past(tc_q) + 1'b1)) && (pc_q == '0));

  a_r4_no_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_mode_i && !cnt_evt_i && !clr_evt_i) |=> $stable(tc_q) && $stable(pc_q));

  a_r2_prescale_step: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_mode_i && !clr_evt_i && (pc_q != match_i))
      |=> (pc_q == PC_W'($past(pc_q) + 1'b1)) && $stable(tc_q));

  a_r2_prescale_roll: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_mode_i && !clr_evt_i && (pc_q == match_i))
      |=> (pc_q == '0) && (tc_q == TC_W'($past(tc_q) + 1'b1)));
endmodule

// File: rtl/tcc_timer_front.sv
`timescale 1ns/1ps
module tcc_timer_front
  import tcc_pkg::*;
#(
  parameter int TC_W = 16,
  parameter int PC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_CAP-1:0] cap_pin_i,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic [PC_W-1:0]  pre_match_i,
  output logic [TC_W-1:0]  tmr_cnt_o,
  output logic [PC_W-1:0]  pre_cnt_o
);
  logic               rst_int_n;
  ctl_t               ctl_q, ctl_d;
  logic [NUM_CAP-1:0] rise, fall;
  logic               clk_mode, cnt_evt, clr_evt;

  tcc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  always_comb begin
    ctl_d = ctl_t'(ctl_wdata_i);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    ctl_q <= '0;
    else if (ctl_we_i) ctl_q <= ctl_d;
  end

  tcc_cap_edge #(.N(NUM_CAP)) u_edge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pin_i  (cap_pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  tcc_event_sel #(.N(NUM_CAP)) u_sel (
    .ctl_i      (ctl_q),
    .rise_i     (rise),
    .fall_i     (fall),
    .clk_mode_o (clk_mode),
    .cnt_evt_o  (cnt_evt),
    .clr_evt_o  (clr_evt)
  );

  tcc_counters #(.TC_W(TC_W), .PC_W(PC_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clk_mode_i (clk_mode),
    .cnt_evt_i  (cnt_evt),
    .clr_evt_i  (clr_evt),
    .match_i    (pre_match_i),
    .tc_o       (tmr_cnt_o),
    .pc_o       (pre_cnt_o)
  );
endmodule

// File: tb/test_tcc_timer_front.sv
`timescale 1ns/1ps
module test_tcc_timer_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cap = 2'b00;
  logic        we = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [15:0] match = 16'hFFFF;
  logic [15:0] tc, pc;
  int          errs = 0;
  int          chks = 0;

  always #2.5 clk = ~clk;

  tcc_timer_front i_tcc_timer_front (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_pin_i   (cap),
    .ctl_we_i    (we),
    .ctl_wdata_i (wdata),
    .pre_match_i (match),
    .tmr_cnt_o   (tc),
    .pre_cnt_o   (pc)
  );

  typedef struct packed {
    logic [7:0]  ctl;
    logic        pin;
    logic [3:0]  pulses;
    logic [15:0] tc;
  } vec_t;

  // control byte, pulsed pin, pulse count, expected timer count
  localparam vec_t VEC [0:6] = '{
    '{8'h01, 1'b0, 4'd3, 16'd3},   // R4 rising, pin 0
    '{8'h02, 1'b0, 4'd3, 16'd3},   // R4 falling, pin 0
    '{8'h03, 1'b0, 4'd3, 16'd6},   // R4 both edges, pin 0
    '{8'h05, 1'b1, 4'd4, 16'd4},   // R5 rising, pin 1 selected
    '{8'h05, 1'b0, 4'd4, 16'd0},   // R5 pin 0 not selected
    '{8'h09, 1'b1, 4'd3, 16'd0},   // R5 reserved select 2
    '{8'h0D, 1'b1, 4'd2, 16'd0}    // R5 reserved select 3
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    chks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [15:0] m);
    rst_n = 1'b0; we = 1'b0; cap = 2'b00; match = m;
    nclk(2);
    rst_n = 1'b1;
    nclk(3);
  endtask

  task automatic wr(input logic [7:0] d);
    we = 1'b1; wdata = d;
    nclk(1);
    we = 1'b0;
  endtask

  task automatic pulse(input int p, input int n);
    for (int i = 0; i < n; i++) begin
      cap[p] = 1'b1; nclk(3);
      cap[p] = 1'b0; nclk(3);
    end
    nclk(4);
  endtask

  initial begin
    #(200000 * 5);
    errs++; chks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    logic [15:0] t0, p0, et, ep;
    @(negedge clk);
    nclk(1);
    // R1 reset state
    check("R1 tc in reset", tc, 16'd0);
    check("R1 pc in reset", pc, 16'd0);
    rst_n = 1'b1;
    nclk(3);
    p0 = pc;
    nclk(1);
    check("R1 default clock mode", pc, p0 + 16'd1);

    // vector table: counting modes and pin select
    for (int v = 0; v < 7; v++) begin
      do_reset(16'hFFFF);
      wr(VEC[v].ctl);
      pulse(int'(VEC[v].pin), int'(VEC[v].pulses));
      check($sformatf("R4/R5 vector %0d tc", v), tc, VEC[v].tc);
      if (VEC[v].tc != 16'd0) check($sformatf("R4 vector %0d pc", v), pc, 16'd0);
    end

    // R2 prescale with match 3
    do_reset(16'd3);
    nclk(2);
    t0 = tc; p0 = pc; et = t0; ep = p0;
    nclk(20);
    for (int i = 0; i < 20; i++) begin
      if (ep == 16'd3) begin ep = 16'd0; et = et + 16'd1; end
      else ep = ep + 16'd1;
    end
    check("R2 prescale pc", pc, ep);
    check("R2 prescale tc", tc, et);

    // R3 wrap with match 0
    do_reset(16'd0);
    t0 = tc;
    nclk(1);
    check("R3 step per clock", tc, t0 + 16'd1);
    nclk(65536);
    check("R3 wrap", tc, t0 + 16'd1);

    // R6 clear on falling edge of pin 1
    do_reset(16'hFFFF);
    wr(8'h71);
    pulse(0, 3);
    check("R6 count before clear", tc, 16'd3);
    cap[1] = 1'b1; nclk(5);
    check("R6 rise not selected", tc, 16'd3);
    cap[1] = 1'b0; nclk(5);
    check("R6 clear tc", tc, 16'd0);
    check("R6 clear pc", pc, 16'd0);

    // R7 clear disabled, then reserved clear code
    do_reset(16'hFFFF);
    wr(8'h61);
    pulse(0, 2);
    pulse(1, 2);
    check("R7 clear disabled", tc, 16'd2);
    wr(8'h91);
    pulse(1, 2);
    pulse(0, 1);
    check("R7 reserved clear code", tc, 16'd3);

    // R8 clear and count on the same edge
    do_reset(16'hFFFF);
    wr(8'h11);
    pulse(0, 3);
    check("R8 clear wins tc", tc, 16'd0);
    check("R8 clear wins pc", pc, 16'd0);

    // R9 latency: clock mode, clear on rise of pin 0
    do_reset(16'd0);
    wr(8'h10);
    nclk(2);
    cap[0] = 1'b1;
    nclk(2);
    check("R9 no clear before third edge", tc == 16'd0 ? 16'd1 : 16'd0, 16'd0);
    nclk(1);
    check("R9 clear at third edge tc", tc, 16'd0);
    check("R9 clear at third edge pc", pc, 16'd0);
    nclk(1);
    check("R9 count resumes", tc, 16'd1);
    cap[0] = 1'b0;

    // R10 control write timing
    do_reset(16'hFFFF);
    nclk(2);
    p0 = pc;
    we = 1'b1; wdata = 8'h01;
    nclk(1);
    we = 1'b0;
    check("R10 storing edge uses old mode", pc, p0 + 16'd1);
    p0 = pc;
    nclk(3);
    check("R10 new mode holds pc", pc, p0);

    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule